// File: doc/BRIEF.md
# Branch Target Buffer

This block gives the fetch stage a guess for the next fetch address while an instruction is still being fetched and before anyone has decoded it. It is a direct-mapped table. Each slot holds a valid flag, a short tag taken from the branch address, the address the branch went to last time, and a few opaque prediction bits. A lookup with the current fetch address returns the stored target when the slot's tag matches. Otherwise it returns the sequential address, the fetch address plus four. This means a missing entry is handled exactly like an instruction that is not a branch.

The table only ever holds branches that were taken. When a branch resolves in the back end, the update port reports its address, its direction, its target and the prediction bits to store. A taken branch claims its slot and overwrites whatever was there. A branch that hits its own entry but turns out not taken has that entry removed. The tag is partial, so two addresses that differ only above the tag bits share an entry. This aliasing is accepted in exchange for smaller storage.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses until a taken update has been made.
- R2: The slot index is fetch address bits [7:2] (64 slots), and the tag is bits [15:8]. An address with the same index but a different tag misses.
- R3: A lookup hits when the indexed slot is valid and its tag equals the address tag. On a hit, `pred_hit` is 1 and `pred_next_pc` is the stored target, in the same cycle as the lookup.
- R4: On a miss, `pred_hit` is 0, `pred_next_pc` is the fetch address plus 4 (modulo 2^32) and `pred_state` is 0.
- R5: An update with `upd_valid`=1 and `upd_taken`=1 writes valid, tag, target and state into its slot at the clock edge. It replaces any earlier occupant, and lookups see it from the next cycle.
- R6: An update with `upd_valid`=1 and `upd_taken`=0 whose slot is valid with a matching tag invalidates that slot.
- R7: A not-taken update whose slot is invalid or holds a different tag leaves the table unchanged.
- R8: A lookup in the same cycle as an update to the same slot returns the contents from before the update.
- R9: Addresses that differ only in bits [31:16] share a slot and its tag, so they hit the same entry.
- R10: On a hit, `pred_state` returns the prediction bits stored by the last taken update of that slot.
- R11: While `upd_valid` is 0, the update inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | Lookup found a matching taken-branch entry |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_state | output | 2 | Stored prediction bits on a hit, 0 on a miss |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved target address |
| upd_state | input | 2 | Prediction bits to store with a taken entry |

## Verification
The lookup path has no registers, so `pred_hit`, `pred_next_pc` and `pred_state` are due in the same cycle as `fetch_pc`. An update becomes visible only to lookups made in the cycle after its clock edge. The bench therefore drives inputs on the falling edge and compares the outputs against its model one nanosecond later, before the rising edge. It applies the reported update to the model only after that rising edge. Because of this ordering, a lookup and an update in the same cycle are always compared against the old contents, which is what R8 requires.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Action the update decoder asks of the storage array in one cycle.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_FILL = 2'd1,
    OP_DROP = 2'd2
  } btb_op_e;

endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [1:0] stg_d;
  logic [1:0] stg_q;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= 2'b00;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign rst_ns = stg_q[1];

endmodule

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int TAG_W = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);

  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;

  assign idx_o = pc_i[TAG_LO-1:IDX_LO];
  assign tag_o = pc_i[TAG_LO+TAG_W-1:TAG_LO];

endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int TAG_W = 8,
  parameter int ST_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  btb_op_e          op_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i,
  input  logic [ST_W-1:0]  wr_st_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic             lk_vld_o,
  output logic [TAG_W-1:0] lk_tag_o,
  output logic [PC_W-1:0]  lk_tgt_o,
  output logic [ST_W-1:0]  lk_st_o,
  output logic             up_vld_o,
  output logic [TAG_W-1:0] up_tag_o
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_a [ENTRIES];
  logic [PC_W-1:0]    tgt_a [ENTRIES];
  logic [ST_W-1:0]    st_a  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic             sel;
    logic             fill_en;
    logic             drop_en;
    logic             v_d;
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic [PC_W-1:0]  g_q;
    logic [ST_W-1:0]  s_q;

    assign sel     = (wr_idx_i == IDX_W'(e));
    assign fill_en = sel && (op_i == OP_FILL);
    assign drop_en = sel && (op_i == OP_DROP);

    always_comb begin
      v_d = v_q;
      if (fill_en) begin
        v_d = 1'b1;
      end else if (drop_en) begin
        v_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else begin
        v_q <= v_d;
      end
    end

    // Payload flops carry no reset: the valid flag guards them.
    always_ff @(posedge clk) begin
      if (fill_en) begin
        t_q <= wr_tag_i;
        g_q <= wr_tgt_i;
        s_q <= wr_st_i;
      end
    end

    assign vld_q[e] = v_q;
    assign tag_a[e] = t_q;
    assign tgt_a[e] = g_q;
    assign st_a[e]  = s_q;
  end

  assign lk_vld_o = vld_q[lk_idx_i];
  assign lk_tag_o = tag_a[lk_idx_i];
  assign lk_tgt_o = tgt_a[lk_idx_i];
  assign lk_st_o  = st_a[lk_idx_i];
  assign up_vld_o = vld_q[wr_idx_i];
  assign up_tag_o = tag_a[wr_idx_i];

  assert_fill_sets_valid_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (op_i == OP_FILL) |=> vld_q[$past(wr_idx_i)]
  );

  assert_drop_clears_valid_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (op_i == OP_DROP) |=> !vld_q[$past(wr_idx_i)]
  );

  assert_drop_only_valid_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (op_i == OP_DROP) |-> up_vld_o
  );

  assert_idle_holds_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (op_i == OP_NONE) |=> (vld_q == $past(vld_q))
  );

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int PC_W  = 32,
  parameter int TAG_W = 8,
  parameter int ST_W  = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [TAG_W-1:0] pc_tag_i,
  input  logic             ent_vld_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [PC_W-1:0]  ent_tgt_i,
  input  logic [ST_W-1:0]  ent_st_i,
  output logic             hit_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic [ST_W-1:0]  st_o
);

  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0] seq_pc;

  assign seq_pc = pc_i + STEP;

  always_comb begin
    hit_o     = ent_vld_i && (ent_tag_i == pc_tag_i);
    next_pc_o = seq_pc;
    st_o      = '0;
    if (hit_o) begin
      next_pc_o = ent_tgt_i;
      st_o      = ent_st_i;
    end
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int TAG_W = 8,
  parameter int ST_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  output logic [ST_W-1:0] pred_state,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic [ST_W-1:0] upd_state
);

  logic             rst_ns;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] up_idx;
  logic [TAG_W-1:0] up_tag;
  logic             ent_vld;
  logic [TAG_W-1:0] ent_tag;
  logic [PC_W-1:0]  ent_tgt;
  logic [ST_W-1:0]  ent_st;
  logic             up_ent_vld;
  logic [TAG_W-1:0] up_ent_tag;
  btb_op_e          op;

  btb_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_lk (
    .pc_i  (fetch_pc),
    .idx_o (lk_idx),
    .tag_o (lk_tag)
  );

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_up (
    .pc_i  (upd_pc),
    .idx_o (up_idx),
    .tag_o (up_tag)
  );

  // Taken branches claim their slot; a not-taken branch removes only its own entry.
  always_comb begin
    op = OP_NONE;
    if (upd_valid) begin
      if (upd_taken) begin
        op = OP_FILL;
      end else if (up_ent_vld && (up_ent_tag == up_tag)) begin
        op = OP_DROP;
      end
    end
  end

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ST_W(ST_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_ns),
    .op_i     (op),
    .wr_idx_i (up_idx),
    .wr_tag_i (up_tag),
    .wr_tgt_i (upd_target),
    .wr_st_i  (upd_state),
    .lk_idx_i (lk_idx),
    .lk_vld_o (ent_vld),
    .lk_tag_o (ent_tag),
    .lk_tgt_o (ent_tgt),
    .lk_st_o  (ent_st),
    .up_vld_o (up_ent_vld),
    .up_tag_o (up_ent_tag)
  );

  btb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W), .ST_W(ST_W)) u_lookup (
    .pc_i      (fetch_pc),
    .pc_tag_i  (lk_tag),
    .ent_vld_i (ent_vld),
    .ent_tag_i (ent_tag),
    .ent_tgt_i (ent_tgt),
    .ent_st_i  (ent_st),
    .hit_o     (pred_hit),
    .next_pc_o (pred_next_pc),
    .st_o      (pred_state)
  );

  assert_miss_falls_through_R4: assert property (
    @(posedge clk) disable iff (!rst_ns)
    !pred_hit |-> (pred_next_pc == fetch_pc + PC_W'(4))
  );

  assert_miss_state_zero_R4: assert property (
    @(posedge clk) disable iff (!rst_ns)
    !pred_hit |-> (pred_state == '0)
  );

  assert_not_taken_never_fills_R7: assert property (
    @(posedge clk) disable iff (!rst_ns)
    (upd_valid && !upd_taken) |-> (op != OP_FILL)
  );

endmodule

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        pred_hit;
  logic [31:0] pred_next_pc;
  logic [1:0]  pred_state;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic [31:0] upd_target;
  logic [1:0]  upd_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural model of the table.
  bit          m_vld [64];
  int          m_tag [64];
  logic [31:0] m_tgt [64];
  int          m_st  [64];

  always #2.5 clk = ~clk;

  btb_predictor u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_next_pc (pred_next_pc),
    .pred_state   (pred_state),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target),
    .upd_state    (upd_state)
  );

  function automatic int slot_of(input logic [31:0] a);
    return int'((a >> 2) % 64);
  endfunction

  function automatic int tag_of(input logic [31:0] a);
    return int'((a >> 8) % 256);
  endfunction

  // One cycle: drive, compare before the rising edge, then advance the model.
  task automatic step(input string req, input logic [31:0] fpc,
                      input bit uv, input logic [31:0] upc, input bit ut,
                      input logic [31:0] utg, input logic [1:0] ust);
    int          i;
    int          j;
    bit          e_hit;
    logic [31:0] e_nxt;
    logic [1:0]  e_st;
    fetch_pc   = fpc;
    upd_valid  = uv;
    upd_pc     = upc;
    upd_taken  = ut;
    upd_target = utg;
    upd_state  = ust;
    #1;
    i     = slot_of(fpc);
    e_hit = m_vld[i] && (m_tag[i] == tag_of(fpc));
    e_nxt = e_hit ? m_tgt[i] : fpc + 32'd4;
    e_st  = e_hit ? 2'(m_st[i]) : 2'd0;
    checks++;
    if (pred_hit !== e_hit || pred_next_pc !== e_nxt || pred_state !== e_st) begin
      fails++;
      $display("FAIL %s pc=%h: got hit=%0b next=%h st=%0d, expected hit=%0b next=%h st=%0d",
               req, fpc, pred_hit, pred_next_pc, pred_state, e_hit, e_nxt, e_st);
    end
    @(posedge clk);
    if (uv) begin
      j = slot_of(upc);
      if (ut) begin
        m_vld[j] = 1'b1;
        m_tag[j] = tag_of(upc);
        m_tgt[j] = utg;
        m_st[j]  = int'(ust);
      end else if (m_vld[j] && m_tag[j] == tag_of(upc)) begin
        m_vld[j] = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  task automatic look(input string req, input logic [31:0] fpc);
    step(req, fpc, 1'b0, 32'h0, 1'b0, 32'h0, 2'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected finish in time");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] lf;
    for (int k = 0; k < 64; k++) m_vld[k] = 1'b0;
    rst_n = 1'b0;
    fetch_pc = '0; upd_valid = 0; upd_pc = '0; upd_taken = 0; upd_target = '0; upd_state = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R4: empty table falls through.
    look("R1", 32'h0000_0100);
    look("R1", 32'h0000_2000);
    look("R4", 32'hFFFF_FFFC);

    a = 32'h0000_1234;
    b = a ^ 32'h0000_0100;
    // R8: a lookup during the fill of the same slot still misses.
    step("R8", a, 1'b1, a, 1'b1, 32'h0000_8000, 2'd2);
    look("R3", a);                       // R3 R5 R10: hit with target and state
    look("R9", a + 32'h0001_0000);       // R9: alias above the tag
    look("R2", b);                       // R2: other tag, same slot
    // R7: a not-taken update with a foreign tag leaves the entry.
    step("R7", a, 1'b1, b, 1'b0, 32'h0, 2'd0);
    look("R7", a);
    // R11: ignored while upd_valid is low.
    step("R11", a, 1'b0, b, 1'b1, 32'h0000_9999, 2'd1);
    look("R11", a);
    look("R11", b);
    // R5: replacement by another tag.
    step("R5", b, 1'b1, b, 1'b1, 32'h0000_9000, 2'd3);
    look("R5", a);
    look("R10", b);
    // R6: a not-taken own entry is dropped; R8 same-cycle lookup sees it still.
    step("R8", b, 1'b1, b, 1'b0, 32'h0, 2'd0);
    look("R6", b);

    // R3: several slots filled and read back.
    for (int k = 0; k < 16; k++)
      step("R5", 32'h0, 1'b1, 32'(k * 4 + 32'h0000_0700), 1'b1, 32'(32'h0004_0000 + k * 16), 2'(k));
    for (int k = 0; k < 16; k++)
      look("R3", 32'(k * 4 + 32'h0000_0700));

    // Mixed traffic on a small address set, compared each cycle.
    lf = 32'hACE1_2345;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step("R3", {lf[31:16], 6'd0, lf[5:4], 3'd0, lf[2:0], 2'b00},
           lf[12], {lf[23:16], 8'd0, 6'd0, lf[7:6], 3'd0, lf[10:8], 2'b00},
           lf[13], {lf[29:14], 16'h0ABC}, lf[15:14]);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule